// File: doc/BRIEF.md
# Parallel ADC Conversion Read Controller

This block sits on the host side of a sampling converter that has a 12-bit parallel output. A single start request makes it pull the read/convert strobe low with chip select asserted, which begins a conversion. It then follows the converter's busy flag through its low phase and back to high. Once the flag has returned high, the converter has finished the conversion and updated its output register. The controller then reads the two's-complement word from the shared data bus and presents it as a signed sample with a one-cycle valid pulse.

The host never drives the data lines. It reads them only in a window where strobe is high, select is low and busy is high, which is the only combination in which the converter drives the bus. While a conversion runs, the controller holds both control pins steady. A mode input keeps chip select low all the time, so that the strobe pin alone both starts conversions and enables the output. A start request that arrives in the middle of a conversion is dropped and reported. A programmable wait limit stops the controller from hanging on a converter that never finishes.

Top module: `adc_par_rd_ctrl`

## Requirements
- R1: After reset, rc_o is 1, cs_n_o is 1 (with cs_hold_i low), and valid_o, overrun_o and timeout_o are all 0.
- R2: A start_i pulse in idle drives rc_o low for exactly START_CYC cycles (default 2), starting the cycle after the request. cs_n_o is low whenever rc_o is low. Exactly one conversion starts.
- R3: With cs_hold_i low, cs_n_o is high in idle and low from the start of a conversion until the sample has been captured.
- R4: With cs_hold_i high, cs_n_o stays low, including in idle.
- R5: busy_i passes through a synchronizer of SYNC_STAGES flops (default 2). After busy_i has been seen low, a rising edge of busy_i makes valid_o go high at the fourth clock edge after the rise.
- R6: When valid_o is high, sample_o holds data_i read as signed 12-bit two's complement (bit 11 is the sign, so 0x800 is -2048 and 0x7FF is 2047). The word is sampled in a cycle with rc_o high, cs_n_o low and busy_i high. valid_o is high for one cycle only.
- R7: While busy_i is low, cs_n_o does not change and rc_o does not fall. The host has no driver on data_i.
- R8: A start_i arriving when not idle starts no extra conversion and raises overrun_o for one cycle, in the cycle after the request.
- R9: If busy_i has not risen again after tmo_limit_i + 1 cycles of waiting (counted from rc_o returning high), timeout_o pulses for one cycle, no sample is produced and the controller returns to idle, ready for a new start. tmo_limit_i must be at least 1.
- R10: timeout_o and valid_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, one cycle |
| cs_hold_i | input | 1 | Keep chip select asserted at all times |
| tmo_limit_i | input | TMO_W | Wait limit in cycles |
| rc_o | output | 1 | Read/convert strobe; low starts a conversion |
| cs_n_o | output | 1 | Active-low chip select |
| busy_i | input | 1 | Converter busy flag; low while converting |
| data_i | input | DATA_W | Converter data bus |
| sample_o | output | DATA_W | Captured signed sample |
| valid_o | output | 1 | sample_o is new, one cycle |
| overrun_o | output | 1 | Start request dropped, one cycle |
| timeout_o | output | 1 | Wait aborted, one cycle |

## Verification
The hardest situations to reach from the ports are a converter that never raises busy again and a second start request that lands in the middle of a conversion. The bench's behavioural converter has a stuck mode that holds busy low. In that mode the wait limit expires, and the bench then releases the model and checks that a fresh conversion completes. Extra start pulses are injected only during conversions long enough to keep the controller busy, so that the drop and its report are measured at an exact cycle. Random words, conversion lengths and chip-select modes are mixed with the extreme codes around the sign boundary.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_WLOW  = 3'd2,
      ST_WHIGH = 3'd3,
      ST_CAPT  = 3'd4
   } rd_state_e;
endpackage

// File: rtl/adc_rd_sync.sv
// Multi-flop synchronizer for the busy flag with rising-edge detect.
module adc_rd_sync #(
   parameter int  STAGES  = 2,
   parameter bit  RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("adc_rd_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
         prev_q  <= RST_VAL;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign q_o    = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/adc_rd_wdog.sv
// Wait-limit counter: runs while enabled, flags when the limit is reached.
module adc_rd_wdog #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic [W-1:0] limit_i,
   output logic         expired_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (run_i) cnt_q <= cnt_q + 1'b1;
      else            cnt_q <= '0;
   end

   assign expired_o = run_i && (cnt_q == limit_i);
endmodule

// File: rtl/adc_rd_fsm.sv
// Sequencer: strobe generation, busy tracking, capture and status pulses.
module adc_rd_fsm
   import adc_rd_pkg::*;
#(
   parameter int DATA_W    = 12,
   parameter int START_CYC = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic                     cs_hold_i,
   input  logic                     busy_s_i,
   input  logic                     busy_rise_i,
   input  logic                     expired_i,
   input  logic [DATA_W-1:0]        data_i,
   output logic                     wait_run_o,
   output logic                     rc_o,
   output logic                     cs_n_o,
   output logic signed [DATA_W-1:0] sample_o,
   output logic                     valid_o,
   output logic                     overrun_o,
   output logic                     timeout_o
);
   localparam int SCW = $clog2(START_CYC + 1);
   localparam logic [SCW-1:0] S_LAST = SCW'(START_CYC - 1);

   rd_state_e state_q, state_d;
   logic [SCW-1:0] scnt_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start_i) state_d = ST_START;
         ST_START: if (scnt_q == S_LAST) state_d = ST_WLOW;
         ST_WLOW: begin
            if (expired_i)      state_d = ST_IDLE;
            else if (!busy_s_i) state_d = ST_WHIGH;
         end
         ST_WHIGH: begin
            if (expired_i)        state_d = ST_IDLE;
            else if (busy_rise_i) state_d = ST_CAPT;
         end
         ST_CAPT:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   assign wait_run_o = (state_q == ST_WLOW) || (state_q == ST_WHIGH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         scnt_q    <= '0;
         rc_o      <= 1'b1;
         cs_n_o    <= 1'b1;
         sample_o  <= '0;
         valid_o   <= 1'b0;
         overrun_o <= 1'b0;
         timeout_o <= 1'b0;
      end else begin
         state_q   <= state_d;
         scnt_q    <= (state_q == ST_START) ? scnt_q + 1'b1 : '0;
         rc_o      <= (state_d != ST_START);
         cs_n_o    <= !(cs_hold_i || (state_d != ST_IDLE));
         valid_o   <= (state_q == ST_CAPT);
         overrun_o <= start_i && (state_q != ST_IDLE);
         timeout_o <= expired_i && wait_run_o;
         if (state_q == ST_CAPT) sample_o <= $signed(data_i);
      end
   end
endmodule

// File: rtl/adc_par_rd_ctrl.sv
module adc_par_rd_ctrl #(
   parameter int DATA_W      = 12,
   parameter int START_CYC   = 2,
   parameter int SYNC_STAGES = 2,
   parameter int TMO_W       = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic                     cs_hold_i,
   input  logic [TMO_W-1:0]         tmo_limit_i,
   output logic                     rc_o,
   output logic                     cs_n_o,
   input  logic                     busy_i,
   input  logic [DATA_W-1:0]        data_i,
   output logic signed [DATA_W-1:0] sample_o,
   output logic                     valid_o,
   output logic                     overrun_o,
   output logic                     timeout_o
);
   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("adc_par_rd_ctrl: DATA_W must be at least 2");
      end
      if (START_CYC < 2) begin : g_bad_s
         $error("adc_par_rd_ctrl: START_CYC must be at least 2");
      end
      if (TMO_W < 2) begin : g_bad_t
         $error("adc_par_rd_ctrl: TMO_W must be at least 2");
      end
   endgenerate

   logic busy_s, busy_rise, expired, wait_run;

   adc_rd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(busy_i), .q_o(busy_s), .rise_o(busy_rise)
   );

   adc_rd_wdog #(.W(TMO_W)) u_wdog (
      .clk(clk), .rst_n(rst_n), .run_i(wait_run), .limit_i(tmo_limit_i),
      .expired_o(expired)
   );

   adc_rd_fsm #(.DATA_W(DATA_W), .START_CYC(START_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cs_hold_i(cs_hold_i),
      .busy_s_i(busy_s), .busy_rise_i(busy_rise), .expired_i(expired),
      .data_i(data_i), .wait_run_o(wait_run), .rc_o(rc_o), .cs_n_o(cs_n_o),
      .sample_o(sample_o), .valid_o(valid_o), .overrun_o(overrun_o),
      .timeout_o(timeout_o)
   );
endmodule

// File: rtl/adc_par_rd_ctrl_chk.sv
module adc_par_rd_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic cs_hold_i,
   input logic rc_o,
   input logic cs_n_o,
   input logic busy_i,
   input logic valid_o,
   input logic overrun_o,
   input logic timeout_o
);
   // R2
   rc_low_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rc_o |-> !cs_n_o);

   // R2
   rc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rc_o) |=> !rc_o);

   // R4
   cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cs_hold_i) && $past(rst_n)) |-> !cs_n_o);

   // R6
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R6
   read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> ($past(rc_o) && !$past(cs_n_o) && $past(busy_i)));

   // R8
   overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o |-> $past(start_i));

   // R10
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_o && timeout_o));
endmodule

bind adc_par_rd_ctrl adc_par_rd_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .cs_hold_i(cs_hold_i),
   .rc_o(rc_o), .cs_n_o(cs_n_o), .busy_i(busy_i), .valid_o(valid_o),
   .overrun_o(overrun_o), .timeout_o(timeout_o)
);

// File: tb/adc_par_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_par_rd_ctrl_tb_top;
   localparam int DATA_W    = 12;
   localparam int START_CYC = 2;
   localparam int TMO_W     = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic cs_hold_i = 1'b0;
   logic [TMO_W-1:0] tmo_limit_i = 16'd200;
   logic rc_o, cs_n_o, valid_o, overrun_o, timeout_o;
   logic signed [DATA_W-1:0] sample_o;
   wire  [DATA_W-1:0] adc_bus;

   // converter model state
   logic busy_m = 1'b1;
   logic [DATA_W-1:0] out_word = '0;
   logic [DATA_W-1:0] next_word = '0;
   int   conv_len = 8;
   int   left = 0;
   bit   conv = 0;
   bit   stuck = 0;
   bit   abort_m = 0;
   int   conv_cnt = 0;
   int   host_viol = 0;
   int   rise_cyc = 0;
   int   cyc = 0;
   logic cs_at = 1'b0;
   logic rc_prev = 1'b0;

   int nchk = 0;
   int nfail = 0;
   bit done = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign adc_bus = (rc_o && !cs_n_o && busy_m) ? out_word : {DATA_W{1'bz}};

   adc_par_rd_ctrl #(.DATA_W(DATA_W), .START_CYC(START_CYC), .TMO_W(TMO_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cs_hold_i(cs_hold_i),
      .tmo_limit_i(tmo_limit_i), .rc_o(rc_o), .cs_n_o(cs_n_o), .busy_i(busy_m),
      .data_i(adc_bus), .sample_o(sample_o), .valid_o(valid_o),
      .overrun_o(overrun_o), .timeout_o(timeout_o)
   );

   // Behavioural converter; also polices host activity while busy is low (R7)
   always @(negedge clk) begin
      if (!rst_n || abort_m) begin
         busy_m = 1'b1;
         conv   = 0;
      end else if (conv) begin
         if (!stuck) begin
            if ((cs_n_o != cs_at) || (rc_prev && !rc_o)) host_viol++;
            rc_prev = rc_o;
         end
         if (!stuck) begin
            if (left <= 1) begin
               out_word = next_word;
               busy_m   = 1'b1;
               conv     = 0;
               rise_cyc = cyc;
            end else left--;
         end
      end else if (!rc_o && !cs_n_o && busy_m) begin
         conv     = 1;
         busy_m   = 1'b0;
         left     = conv_len;
         conv_cnt++;
         cs_at    = cs_n_o;
         rc_prev  = rc_o;
      end
   end

   function automatic int exp_signed(input logic [DATA_W-1:0] w);
      return w[DATA_W-1] ? int'(w) - (1 << DATA_W) : int'(w);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_conv(input logic [DATA_W-1:0] w, input int len,
                           input bit hold, input bit inj);
      int c0, lowc, k;
      @(negedge clk);
      cs_hold_i = hold;
      next_word = w;
      conv_len  = len;
      @(negedge clk);
      @(negedge clk);
      if (hold) chk(cs_n_o == 1'b0, "R4 idle cs_n", int'(cs_n_o), 0);
      else      chk(cs_n_o == 1'b1, "R3 idle cs_n", int'(cs_n_o), 1);
      c0 = conv_cnt;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(!rc_o && !cs_n_o, "R2 strobe with select", int'({rc_o, cs_n_o}), 0);
      lowc = 1;
      while (!rc_o && lowc < 50) begin
         @(negedge clk);
         if (!rc_o) lowc++;
      end
      chk(lowc == START_CYC, "R2 strobe width", lowc, START_CYC);
      chk(!cs_n_o, "R3 select during wait", int'(cs_n_o), 0);
      k = 0;
      while (!valid_o && !timeout_o && k < 2000) begin
         if (inj && k == 1) start_i = 1'b1;
         if (inj && k == 2) begin
            start_i = 1'b0;
            chk(overrun_o == 1'b1, "R8 overrun pulse", int'(overrun_o), 1);
         end
         @(negedge clk);
         k++;
      end
      start_i = 1'b0;
      chk(valid_o == 1'b1, "R5 valid seen", int'(valid_o), 1);
      chk(cyc - rise_cyc == 4, "R5 latency", cyc - rise_cyc, 4);
      chk(int'(sample_o) == exp_signed(w), "R6 sample", int'(sample_o), exp_signed(w));
      chk(conv_cnt == c0 + 1, inj ? "R8 one conversion" : "R2 one conversion",
          conv_cnt - c0, 1);
      @(negedge clk);
      chk(!valid_o, "R6 valid width", int'(valid_o), 0);
      chk(!overrun_o && !timeout_o, "R10 no stray flags", int'({overrun_o, timeout_o}), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int k;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rc_o && cs_n_o, "R1 pins", int'({rc_o, cs_n_o}), 3);
      chk(!valid_o && !overrun_o && !timeout_o, "R1 flags",
          int'({valid_o, overrun_o, timeout_o}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(rc_o && cs_n_o && !valid_o, "R1 after release", int'({rc_o, cs_n_o, valid_o}), 6);

      // directed corner words
      run_conv(12'h800, 6, 1'b0, 1'b0);
      run_conv(12'h7FF, 4, 1'b1, 1'b0);
      run_conv(12'h000, 12, 1'b0, 1'b1);
      run_conv(12'hFFF, 15, 1'b1, 1'b1);

      // random mix
      for (int i = 0; i < 40; i++) begin
         logic [DATA_W-1:0] w;
         int len;
         bit hold, inj;
         w    = DATA_W'($urandom);
         len  = 4 + int'($urandom % 30);
         hold = bit'($urandom % 2);
         inj  = (len >= 10) && ($urandom % 3 == 0);
         run_conv(w, len, hold, inj);
      end

      // R9 converter stuck with busy low
      tmo_limit_i = 16'd20;
      cs_hold_i   = 1'b0;
      stuck       = 1;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (!rc_o) @(negedge clk);
      k = 0;
      while (!timeout_o && !valid_o && k < 500) begin
         @(negedge clk);
         k++;
      end
      chk(timeout_o == 1'b1, "R9 timeout raised", int'(timeout_o), 1);
      chk(k == 21, "R9 timeout cycle", k, 21);
      chk(!valid_o, "R10 no sample on timeout", int'(valid_o), 0);
      @(negedge clk);
      chk(!timeout_o && cs_n_o, "R9 back to idle", int'({timeout_o, cs_n_o}), 1);
      abort_m = 1;
      @(negedge clk);
      abort_m = 0;
      stuck   = 0;
      tmo_limit_i = 16'd200;
      repeat (4) @(negedge clk);
      run_conv(12'h5A3, 9, 1'b0, 1'b0);

      chk(host_viol == 0, "R7 host quiet while busy low", host_viol, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule